// File: doc/BRIEF.md
# Sector Cache with Selectable Write-Miss Policy

A small direct-mapped data cache for word-addressed processor requests. Each line is divided into one-word sectors. Every sector carries its own valid bit and its own dirty bit, so the cache can hold part of a line. On the processor side the cache accepts one read or write at a time and answers every request with a one-cycle response pulse. On the memory side it issues single-word reads and writes through a valid/ready handshake. Each read is answered by exactly one response beat.

A static two-bit mode input chooses what happens when a write misses. Fetch-merge mode brings the line in, updates the word and writes the word through to memory. Write-around mode sends the word to memory and leaves the cache as it was. Allocate mode takes the line for the new tag without reading memory. It keeps only the written word and marks it valid and dirty. This suits push-style code that writes every word of a line before reading any of it. Read misses always load the missing sectors from memory. A line that has dirty sectors writes them back before it is replaced.

Top module: `sector_cache`

## Requirements
- R1: While reset is asserted and right after it, every sector is invalid, req_ready_o is 1, and mem_req_valid_o and rsp_valid_o are 0. The first read to any line therefore misses.
- R2: A read that misses on the tag loads all 4 sectors with one memory read each. The read returns the word that memory holds.
- R3: A read hit makes no memory access. rsp_valid_o is high for exactly one cycle: the cycle right after the edge that accepted the request.
- R4: In mode 0 (fetch-merge), a write miss loads the line, stores the new word in the cache, and then issues one memory write of that word.
- R5: In mode 1 (write-around, and mode 3 acts the same way), a write miss issues one memory write and changes no cache state. A later read of that address misses.
- R6: In mode 2 (allocate), a write never issues a memory read. On a tag miss the line takes the new tag, and only the written sector becomes valid.
- R7: A read whose tag matches but whose sector is invalid loads only the invalid sectors. Words that were already written are kept.
- R8: In mode 2, a write to a line with a matching tag updates the word and marks that sector valid and dirty. It makes no memory access.
- R9: Before a line changes tag, each of its dirty sectors is written back with one memory write.
- R10: In mode 0 or mode 1, a write hit updates the cached word, issues one memory write, and leaves that sector clean.
- R11: req_ready_o is 0 from the accepting edge until the response, and in particular while any memory request is pending. Every response belongs to one accepted request.
- R12: A memory request that has not been accepted keeps its valid, address and data unchanged.

Address fields run from most to least significant: tag, then a 4-bit index, then a 2-bit sector number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wm_mode_i | input | 2 | Write-miss policy: 0 fetch-merge, 1/3 write-around, 2 allocate |
| req_valid_i | input | 1 | Processor request valid |
| req_ready_o | output | 1 | Cache can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Read data, valid with rsp_valid_o |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_req_we_o | output | 1 | Memory request is a write |
| mem_req_addr_o | output | ADDR_W | Memory word address |
| mem_req_wdata_o | output | DATA_W | Memory write data |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_rdata_i | input | DATA_W | Memory read data |

## Verification
A read hit answers in the cycle after the accepting edge. Every other result waits on memory. The memory model grants ready at random and returns read data on the edge after it accepts a read, so each fill takes at least two cycles per sector. The bench changes inputs and samples outputs on falling edges. It counts memory reads and writes from acceptance up to the response pulse and compares those counts, the read data and the hit latency with a reference model of tags and sector states. It therefore never depends on a fixed miss latency.

// File: rtl/sector_cache_pkg.sv
package sector_cache_pkg;
  typedef enum logic [1:0] {
    WM_FETCH  = 2'd0,
    WM_AROUND = 2'd1,
    WM_ALLOC  = 2'd2,
    WM_RSVD   = 2'd3
  } wm_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WB, ST_ALLOC, ST_FILL_REQ, ST_FILL_WAIT, ST_UPD, ST_MEM_WR, ST_RESP
  } cstate_e;
endpackage

// File: rtl/sector_cache_pick.sv
module sector_cache_pick #(
  parameter int N = 4,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic [W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/sector_cache_store.sv
module sector_cache_store #(
  parameter int LINES   = 16,
  parameter int SECTORS = 4,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 6,
  localparam int IDX_W  = $clog2(LINES),
  localparam int SEC_W  = $clog2(SECTORS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [IDX_W-1:0]          idx_i,
  output logic [TAG_W-1:0]          tag_o,
  output logic [SECTORS-1:0]        valid_o,
  output logic [SECTORS-1:0]        dirty_o,
  output logic [SECTORS*DATA_W-1:0] data_o,
  input  logic                      word_we_i,
  input  logic [SEC_W-1:0]          word_sec_i,
  input  logic [DATA_W-1:0]         word_data_i,
  input  logic                      word_dirty_i,
  input  logic                      alloc_i,
  input  logic [TAG_W-1:0]          alloc_tag_i,
  input  logic                      clean_i,
  input  logic [SEC_W-1:0]          clean_sec_i
);
  logic [TAG_W-1:0]   tag_q   [LINES];
  logic [SECTORS-1:0] valid_q [LINES];
  logic [SECTORS-1:0] dirty_q [LINES];
  logic [DATA_W-1:0]  data_q  [LINES][SECTORS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < LINES; l++) begin
        valid_q[l] <= '0;
        dirty_q[l] <= '0;
      end
    end else if (alloc_i) begin
      valid_q[idx_i] <= '0;
      dirty_q[idx_i] <= '0;
    end else begin
      if (word_we_i) begin
        valid_q[idx_i][word_sec_i] <= 1'b1;
        dirty_q[idx_i][word_sec_i] <= word_dirty_i;
      end else if (clean_i) begin
        dirty_q[idx_i][clean_sec_i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_i) tag_q[idx_i] <= alloc_tag_i;
    if (word_we_i) data_q[idx_i][word_sec_i] <= word_data_i;
  end

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];

  for (genvar s = 0; s < SECTORS; s++) begin : g_rd
    assign data_o[s*DATA_W +: DATA_W] = data_q[idx_i][s];
  end
endmodule

// File: rtl/sector_cache_ctrl.sv
module sector_cache_ctrl
  import sector_cache_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int LINES   = 16,
  parameter int SECTORS = 4,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int SEC_W  = $clog2(SECTORS),
  localparam int TAG_W  = ADDR_W - IDX_W - SEC_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [1:0]                wm_mode_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_we_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [DATA_W-1:0]         req_wdata_i,
  output logic                      rsp_valid_o,
  output logic [DATA_W-1:0]         rsp_rdata_o,
  output logic                      mem_req_valid_o,
  input  logic                      mem_req_ready_i,
  output logic                      mem_req_we_o,
  output logic [ADDR_W-1:0]         mem_req_addr_o,
  output logic [DATA_W-1:0]         mem_req_wdata_o,
  input  logic                      mem_rsp_valid_i,
  input  logic [DATA_W-1:0]         mem_rsp_rdata_i,
  output logic [IDX_W-1:0]          idx_o,
  input  logic [TAG_W-1:0]          line_tag_i,
  input  logic [SECTORS-1:0]        line_valid_i,
  input  logic [SECTORS-1:0]        line_dirty_i,
  input  logic [SECTORS*DATA_W-1:0] line_data_i,
  output logic                      word_we_o,
  output logic [SEC_W-1:0]          word_sec_o,
  output logic [DATA_W-1:0]         word_data_o,
  output logic                      word_dirty_o,
  output logic                      alloc_o,
  output logic [TAG_W-1:0]          alloc_tag_o,
  output logic                      clean_o,
  output logic [SEC_W-1:0]          clean_sec_o
);
  cstate_e            state_q, state_d;
  logic               we_q;
  logic [1:0]         mode_q;
  logic [TAG_W-1:0]   tag_q;
  logic [IDX_W-1:0]   idx_q;
  logic [SEC_W-1:0]   sec_q, fill_sec_q;
  logic [DATA_W-1:0]  wdata_q;

  wire idle = (state_q == ST_IDLE);
  wire accept = idle && req_valid_i;

  logic [TAG_W-1:0] lk_tag;
  logic [SEC_W-1:0] lk_sec;
  assign lk_tag = idle ? req_addr_i[ADDR_W-1 -: TAG_W] : tag_q;
  assign lk_sec = idle ? req_addr_i[SEC_W-1:0] : sec_q;
  assign idx_o  = idle ? req_addr_i[SEC_W +: IDX_W] : idx_q;

  wire line_match = (|line_valid_i) && (line_tag_i == lk_tag);
  wire sec_hit    = line_match && line_valid_i[lk_sec];
  wire any_dirty  = |line_dirty_i;

  logic [SEC_W-1:0] dirty_pick, inv_pick;
  sector_cache_pick #(.N(SECTORS)) u_pick_dirty (.req_i(line_dirty_i),  .idx_o(dirty_pick));
  sector_cache_pick #(.N(SECTORS)) u_pick_inv   (.req_i(~line_valid_i), .idx_o(inv_pick));

  wire [SECTORS-1:0] dirty_left = line_dirty_i & ~(SECTORS'(1) << dirty_pick);
  wire [SECTORS-1:0] valid_next = line_valid_i | (SECTORS'(1) << fill_sec_q);

  wire req_alloc = (wm_mode_i == WM_ALLOC);
  wire req_fetch = (wm_mode_i == WM_FETCH);
  wire q_alloc   = (mode_q == WM_ALLOC);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (!req_we_i) begin
          if (sec_hit)         state_d = ST_RESP;
          else if (line_match) state_d = ST_FILL_REQ;
          else                 state_d = any_dirty ? ST_WB : ST_ALLOC;
        end else if (req_alloc) begin
          if (line_match)      state_d = ST_UPD;
          else                 state_d = any_dirty ? ST_WB : ST_ALLOC;
        end else if (req_fetch) begin
          if (sec_hit)         state_d = ST_UPD;
          else if (line_match) state_d = ST_FILL_REQ;
          else                 state_d = any_dirty ? ST_WB : ST_ALLOC;
        end else begin
          state_d = sec_hit ? ST_UPD : ST_MEM_WR;
        end
      end
      ST_WB:        if (mem_req_ready_i && dirty_left == '0) state_d = ST_ALLOC;
      ST_ALLOC:     state_d = (we_q && q_alloc) ? ST_UPD : ST_FILL_REQ;
      ST_FILL_REQ:  if (mem_req_ready_i) state_d = ST_FILL_WAIT;
      ST_FILL_WAIT: if (mem_rsp_valid_i) begin
        if (valid_next == '1) state_d = we_q ? ST_UPD : ST_RESP;
        else                  state_d = ST_FILL_REQ;
      end
      ST_UPD:       state_d = q_alloc ? ST_RESP : ST_MEM_WR;
      ST_MEM_WR:    if (mem_req_ready_i) state_d = ST_RESP;
      ST_RESP:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      we_q       <= 1'b0;
      mode_q     <= '0;
      tag_q      <= '0;
      idx_q      <= '0;
      sec_q      <= '0;
      wdata_q    <= '0;
      fill_sec_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        we_q    <= req_we_i;
        mode_q  <= wm_mode_i;
        tag_q   <= req_addr_i[ADDR_W-1 -: TAG_W];
        idx_q   <= req_addr_i[SEC_W +: IDX_W];
        sec_q   <= req_addr_i[SEC_W-1:0];
        wdata_q <= req_wdata_i;
      end
      if (state_q == ST_FILL_REQ && mem_req_ready_i) fill_sec_q <= inv_pick;
    end
  end

  always_comb begin
    mem_req_valid_o = 1'b0;
    mem_req_we_o    = 1'b0;
    mem_req_addr_o  = '0;
    mem_req_wdata_o = '0;
    word_we_o       = 1'b0;
    word_sec_o      = sec_q;
    word_data_o     = wdata_q;
    word_dirty_o    = 1'b0;
    alloc_o         = 1'b0;
    alloc_tag_o     = tag_q;
    clean_o         = 1'b0;
    clean_sec_o     = dirty_pick;
    unique case (state_q)
      ST_WB: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_addr_o  = {line_tag_i, idx_q, dirty_pick};
        mem_req_wdata_o = line_data_i[dirty_pick*DATA_W +: DATA_W];
        clean_o         = mem_req_ready_i;
      end
      ST_ALLOC: alloc_o = 1'b1;
      ST_FILL_REQ: begin
        mem_req_valid_o = 1'b1;
        mem_req_addr_o  = {tag_q, idx_q, inv_pick};
      end
      ST_FILL_WAIT: begin
        word_we_o   = mem_rsp_valid_i;
        word_sec_o  = fill_sec_q;
        word_data_o = mem_rsp_rdata_i;
      end
      ST_UPD: begin
        word_we_o    = 1'b1;
        word_dirty_o = q_alloc;
      end
      ST_MEM_WR: begin
        mem_req_valid_o = 1'b1;
        mem_req_we_o    = 1'b1;
        mem_req_addr_o  = {tag_q, idx_q, sec_q};
        mem_req_wdata_o = wdata_q;
      end
      default: ;
    endcase
  end

  assign req_ready_o = idle;
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_rdata_o = line_data_i[lk_sec*DATA_W +: DATA_W];
endmodule

// File: rtl/sector_cache.sv
module sector_cache #(
  parameter int ADDR_W  = 12,
  parameter int LINES   = 16,
  parameter int SECTORS = 4,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int SEC_W  = $clog2(SECTORS),
  localparam int TAG_W  = ADDR_W - IDX_W - SEC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        wm_mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i
);
  logic [IDX_W-1:0]          idx;
  logic [TAG_W-1:0]          line_tag, alloc_tag;
  logic [SECTORS-1:0]        line_valid, line_dirty;
  logic [SECTORS*DATA_W-1:0] line_data;
  logic                      word_we, word_dirty, alloc, clean;
  logic [SEC_W-1:0]          word_sec, clean_sec;
  logic [DATA_W-1:0]         word_data;

  sector_cache_ctrl #(
    .ADDR_W(ADDR_W), .LINES(LINES), .SECTORS(SECTORS), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .wm_mode_i, .req_valid_i, .req_ready_o, .req_we_i,
    .req_addr_i, .req_wdata_i, .rsp_valid_o, .rsp_rdata_o,
    .mem_req_valid_o, .mem_req_ready_i, .mem_req_we_o, .mem_req_addr_o,
    .mem_req_wdata_o, .mem_rsp_valid_i, .mem_rsp_rdata_i,
    .idx_o(idx), .line_tag_i(line_tag), .line_valid_i(line_valid),
    .line_dirty_i(line_dirty), .line_data_i(line_data),
    .word_we_o(word_we), .word_sec_o(word_sec), .word_data_o(word_data),
    .word_dirty_o(word_dirty), .alloc_o(alloc), .alloc_tag_o(alloc_tag),
    .clean_o(clean), .clean_sec_o(clean_sec)
  );

  sector_cache_store #(
    .LINES(LINES), .SECTORS(SECTORS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_store (
    .clk_i, .rst_ni, .idx_i(idx), .tag_o(line_tag), .valid_o(line_valid),
    .dirty_o(line_dirty), .data_o(line_data), .word_we_i(word_we),
    .word_sec_i(word_sec), .word_data_i(word_data), .word_dirty_i(word_dirty),
    .alloc_i(alloc), .alloc_tag_i(alloc_tag), .clean_i(clean),
    .clean_sec_i(clean_sec)
  );
endmodule

// File: rtl/sector_cache_chk.sv
module sector_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        wm_mode_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_we_i,
  input logic              rsp_valid_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic              mem_req_we_o,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [DATA_W-1:0] mem_req_wdata_o
);
  logic pend_q, alloc_wr_q;
  wire acc = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      alloc_wr_q <= 1'b0;
    end else if (acc) begin
      pend_q     <= 1'b1;
      alloc_wr_q <= req_we_i && (wm_mode_i == 2'd2);
    end else if (rsp_valid_o) begin
      pend_q     <= 1'b0;
      alloc_wr_q <= 1'b0;
    end
  end

  assert_no_fetch_alloc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_wr_q && mem_req_valid_o |-> mem_req_we_o);

  assert_busy_when_mem_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  assert_rsp_owned_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> pend_q && !req_ready_o);

  assert_rsp_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_mem_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=>
      mem_req_valid_o && $stable(mem_req_we_o) && $stable(mem_req_addr_o)
      && $stable(mem_req_wdata_o));
endmodule

bind sector_cache sector_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/sector_cache_tb_top.sv
module sector_cache_tb_top;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    wm_mode_i = '0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic          req_we_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          rsp_valid_o;
  logic [DW-1:0] rsp_rdata_o;
  logic          mem_req_valid_o;
  logic          mem_req_ready_i = 1'b0;
  logic          mem_req_we_o;
  logic [AW-1:0] mem_req_addr_o;
  logic [DW-1:0] mem_req_wdata_o;
  logic          mem_rsp_valid_i = 1'b0;
  logic [DW-1:0] mem_rsp_rdata_i = '0;

  always #2.5 clk_i = ~clk_i;

  sector_cache dut_i (.*);

  int n_chk = 0, n_bad = 0, n_rd = 0, n_wr = 0;
  bit finished = 1'b0;
  logic [DW-1:0] mem  [1 << AW];
  logic [DW-1:0] gold [1 << AW];
  logic [5:0] m_tag [16];
  logic [3:0] m_v [16];
  logic [3:0] m_d [16];

  always @(negedge clk_i) mem_req_ready_i = ($urandom % 4) != 0;

  always @(posedge clk_i) begin
    mem_rsp_valid_i <= 1'b0;
    if (rst_ni && mem_req_valid_o && mem_req_ready_i) begin
      if (mem_req_we_o) begin
        mem[mem_req_addr_o] <= mem_req_wdata_o;
        n_wr = n_wr + 1;
      end else begin
        mem_rsp_valid_i <= 1'b1;
        mem_rsp_rdata_i <= mem[mem_req_addr_o];
        n_rd = n_rd + 1;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic predict(input bit we, input logic [AW-1:0] a, input logic [1:0] md,
                         input logic [DW-1:0] wd, output int er, output int ew,
                         output string lab);
    logic [5:0] t = a[11:6];
    int ix = int'(a[5:2]);
    int s = int'(a[1:0]);
    bit match = (m_v[ix] != 0) && (m_tag[ix] == t);
    bit hit = match && m_v[ix][s];
    er = 0; ew = 0;
    if (!we) begin
      if (hit) lab = "R3";
      else if (match) begin
        lab = "R7"; er = 4 - $countones(m_v[ix]); m_v[ix] = 4'hf;
      end else begin
        ew = $countones(m_d[ix]); lab = (ew != 0) ? "R9" : "R2";
        er = 4; m_tag[ix] = t; m_v[ix] = 4'hf; m_d[ix] = 0;
      end
    end else begin
      gold[a] = wd;
      if (md == 2'd2) begin
        if (match) begin
          lab = "R8"; m_v[ix][s] = 1'b1; m_d[ix][s] = 1'b1;
        end else begin
          ew = $countones(m_d[ix]); lab = (ew != 0) ? "R9" : "R6";
          m_tag[ix] = t; m_v[ix] = 4'(1 << s); m_d[ix] = 4'(1 << s);
        end
      end else if (hit) begin
        lab = "R10"; ew = 1; m_d[ix][s] = 1'b0;
      end else if (md == 2'd0) begin
        lab = "R4"; ew = 1;
        if (match) er = 4 - $countones(m_v[ix]);
        else begin
          ew += $countones(m_d[ix]); er = 4; m_tag[ix] = t; m_d[ix] = 0;
        end
        m_v[ix] = 4'hf; m_d[ix][s] = 1'b0;
      end else begin
        lab = "R5"; ew = 1;
      end
    end
  endtask

  task automatic xfer(input bit we, input logic [AW-1:0] a, input logic [1:0] md,
                      input logic [DW-1:0] wd);
    int er, ew, cyc;
    string lab;
    predict(we, a, md, wd, er, ew, lab);
    @(negedge clk_i);
    n_rd = 0; n_wr = 0;
    wm_mode_i = md; req_we_i = we; req_addr_i = a; req_wdata_i = wd; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cyc = 1;
    while (!rsp_valid_o && cyc < 400) begin
      @(negedge clk_i);
      cyc++;
    end
    check(rsp_valid_o == 1'b1, lab, "response", rsp_valid_o, 1);
    check(n_rd == er, lab, "memory reads", n_rd, er);
    check(n_wr == ew, lab, "memory writes", n_wr, ew);
    if (!we) check(rsp_rdata_o == gold[a], lab, "read data", rsp_rdata_o, gold[a]);
    if (!we && lab == "R3") check(cyc == 1, "R3", "hit latency", cyc, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20161204));
    for (int i = 0; i < (1 << AW); i++) begin
      mem[i] = {20'hA5C00, i[11:0]};
      gold[i] = mem[i];
    end
    for (int i = 0; i < 16; i++) begin
      m_tag[i] = 0; m_v[i] = 0; m_d[i] = 0;
    end
    repeat (3) @(negedge clk_i);
    check(req_ready_o == 1'b1, "R1", "ready in reset", req_ready_o, 1);
    check(mem_req_valid_o == 1'b0, "R1", "mem idle in reset", mem_req_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(rsp_valid_o == 1'b0, "R1", "no response after reset", rsp_valid_o, 0);

    xfer(0, 12'h010, 2'd0, 0);                 // R2 first read misses
    xfer(0, 12'h012, 2'd0, 0);                 // R3 hit
    for (int s = 0; s < 4; s++) xfer(1, {6'd1, 4'd2, 2'(s)}, 2'd2, 32'hC0DE_0000 + s); // R6 R8
    for (int s = 0; s < 4; s++) xfer(0, {6'd1, 4'd2, 2'(s)}, 2'd0, 0);
    xfer(1, {6'd2, 4'd2, 2'd1}, 2'd2, 32'h1234_5678);   // R9 four write-backs
    xfer(0, {6'd2, 4'd2, 2'd3}, 2'd0, 0);               // R7 three fills
    xfer(0, {6'd2, 4'd2, 2'd1}, 2'd0, 0);
    xfer(0, {6'd1, 4'd2, 2'd2}, 2'd0, 0);               // written-back data
    xfer(1, {6'd3, 4'd5, 2'd0}, 2'd1, 32'hBEEF_0001);   // R5
    xfer(0, {6'd3, 4'd5, 2'd0}, 2'd0, 0);
    xfer(1, {6'd3, 4'd6, 2'd0}, 2'd3, 32'hBEEF_0002);   // R5 mode 3
    xfer(1, {6'd0, 4'd7, 2'd2}, 2'd0, 32'hFACE_0001);   // R4
    xfer(0, {6'd0, 4'd7, 2'd2}, 2'd0, 0);
    xfer(1, {6'd0, 4'd7, 2'd0}, 2'd0, 32'hFACE_0002);   // R10
    xfer(1, {6'd0, 4'd7, 2'd1}, 2'd1, 32'hFACE_0003);   // R10
    xfer(0, {6'd0, 4'd7, 2'd1}, 2'd0, 0);

    for (int k = 0; k < 1500; k++) begin
      logic [AW-1:0] a = {4'd0, 2'($urandom % 4), 4'($urandom), 2'($urandom)};
      xfer(1'($urandom), a, 2'($urandom), $urandom);
    end
    for (int ix = 0; ix < 16; ix++) xfer(0, {6'd63, 4'(ix), 2'd0}, 2'd0, 0);
    for (int ix = 0; ix < 16; ix++)
      for (int t = 0; t < 4; t++) xfer(0, {6'(t), 4'(ix), 2'(t)}, 2'd0, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule